// File: doc/BRIEF.md
# Interprocessor Mailbox

This block lets several processors on one chip pass 32-bit words to each other through a small memory-mapped register window. It holds a set of independent first-in first-out message queues. Any agent may push a word by writing a queue's message register and pop the oldest word by reading the same register. Per-queue registers report the number of stored words and whether the queue is full, so a sender can avoid overflowing a queue and a receiver can poll for new messages.

A number of users, normally one per processor, each own an interrupt bank. A bank has two event bits for every queue. One bit is set when a word is pushed into that queue. The other is set when a pop frees the first slot of a full queue. Events are recorded whether or not they are enabled. Each user's level interrupt is the OR of its status bits masked by its enable bits, and software clears a status bit by writing a one to it.

A sequencer handles the soft reset. A write to the configuration register starts it. The sequencer empties every queue, clears every bank and the configuration, and drops a reset-done flag for a fixed number of cycles. A read-only revision register and an idle-control field complete the window. The bus port is single-cycle: read data is valid in the cycle of the access, and the pop or write takes effect at the clock edge that ends it.

Top module: `ipc_mailbox`

## Requirements
- R1: After the reset input is released, every queue count and full flag reads 0, every user status and enable register reads 0, all interrupt outputs are low, the configuration register reads 0, and the reset-done bit (bit 0 at 0x014) reads 1.
- R2: A write to the message register of queue m (0x040 + 4*m) appends the written word. A read of that register returns the oldest word and removes it. The register at 0x0C0 + 4*m returns the number of stored words.
- R3: The register at 0x080 + 4*m reads 1 while queue m holds Q_DEPTH words and reads 0 otherwise. A write to a full queue is dropped, and the queue's count and contents do not change.
- R4: A read of an empty queue's message register returns 0, and the queue's count stays 0.
- R5: Every accepted push into queue m sets bit 2*m of the status register of every user (user u's status is at 0x100 + 8*u). A dropped push sets nothing.
- R6: Bit 2*m+1 of every user's status is set only when a pop takes queue m from full to not full. A pop from a queue that is not full does not set it.
- R7: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: The enable register of user u (0x104 + 8*u) reads back what was written. irq_o[u] is high exactly when some bit is set in both that user's status and enable registers.
- R9: The register at 0x000 returns REV_MAJOR in bits [7:4] and REV_MINOR in bits [3:0]. Writes to it have no effect.
- R10: The configuration register at 0x010 stores bit 0 (auto-idle enable, driven on idle_auto_o) and bits [4:3] (idle mode, driven on idle_mode_o, where 2 means smart idle). All other bits read 0.
- R11: Writing 1 to bit 1 at 0x010 starts a soft reset. Reset-done reads 0 for exactly RST_CYCLES cycles after that write and then reads 1. The soft reset empties all queues and clears all status, enable and configuration state.
- R12: A push or pop on one queue leaves the counts of all other queues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Access valid in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during a read cycle |
| irq_o | output | NUM_U | Level interrupt per user |
| idle_auto_o | output | 1 | Auto-idle enable from configuration |
| idle_mode_o | output | 2 | Idle-mode field from configuration |

## Verification
The bench builds the block with its defaults: four queues four words deep, four users and a four-cycle soft reset. A depth of four lets the bench fill a queue within a few accesses. It can then reach the dropped fifth push and the full-to-not-full pop that raises the second event bit. Four users let it show that one event reaches every bank while each bank's enable and clear stay private. The short reset length lets it count the reset-done low window exactly.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    localparam int unsigned ADDR_W = 9;

    localparam logic [ADDR_W-1:0] OFS_REV  = 9'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 9'h010;
    localparam logic [ADDR_W-1:0] OFS_STAT = 9'h014;
    localparam logic [ADDR_W-1:0] BASE_MSG = 9'h040;
    localparam logic [ADDR_W-1:0] BASE_FST = 9'h080;
    localparam logic [ADDR_W-1:0] BASE_MST = 9'h0C0;
    localparam logic [ADDR_W-1:0] BASE_IRQ = 9'h100;

    localparam int unsigned CFG_AUTOIDLE_BIT = 0;
    localparam int unsigned CFG_SRST_BIT     = 1;
    localparam int unsigned CFG_MODE_LSB     = 3;

    typedef enum logic [1:0] {
        SR_READY  = 2'd0,
        SR_FLUSH  = 2'd1,
        SR_SETTLE = 2'd2
    } sr_state_e;

endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              pushed_o,
    output logic              freed_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_acc;
    logic              pop_acc;
    logic              is_full;

    assign is_full  = (count == CNT_W'(DEPTH));
    assign push_acc = push_i && !is_full && !clear_i;
    assign pop_acc  = pop_i && (count != '0) && !clear_i;

    always_ff @(posedge clk) begin
        if (push_acc) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop_acc) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({push_acc, pop_acc})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_o   = (count == '0) ? '0 : mem[rd_ptr];
    assign count_o  = count;
    assign full_o   = is_full;
    assign pushed_o = push_acc;
    assign freed_o  = pop_acc && is_full && !push_acc;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH)) else $error("queue count above depth"); // R3

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clear_i) |=> (full_o && $stable(count_o)))
        else $error("push into full queue changed it"); // R3

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && pop_i && !push_i && !clear_i) |=> (count_o == '0))
        else $error("pop of empty queue changed count"); // R4

endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
    parameter int unsigned EV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic [EV_W-1:0] ev_i,
    input  logic            st_w1c_i,
    input  logic            en_we_i,
    input  logic [EV_W-1:0] wdata_i,
    output logic [EV_W-1:0] status_o,
    output logic [EV_W-1:0] enable_o,
    output logic            irq_o
);

    logic [EV_W-1:0] status;
    logic [EV_W-1:0] enable;
    logic [EV_W-1:0] clr_mask;

    assign clr_mask = st_w1c_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else if (clear_i) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | ev_i;
            if (en_we_i) begin
                enable <= wdata_i;
            end
        end
    end

    assign status_o = status;
    assign enable_o = enable;
    assign irq_o    = |(status & enable);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i && !clear_i) |=> ((status_o & $past(ev_i)) == $past(ev_i)))
        else $error("event did not set status"); // R5

    AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (status_o == '0 && enable_o == '0 && !irq_o))
        else $error("bank not cleared by soft reset"); // R11

    AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w1c_i && !clear_i && ev_i == '0) |=> (status_o == ($past(status_o) & ~$past(wdata_i))))
        else $error("write-one-to-clear misbehaved"); // R7

endmodule

// File: rtl/mbx_srst_fsm.sv
module mbx_srst_fsm
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4,
    localparam int unsigned CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic clear_o,
    output logic done_o
);

    sr_state_e     state;
    sr_state_e     state_nx;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(RST_CYCLES - 2));

    always_comb begin
        state_nx = state;
        unique case (state)
            SR_READY:  if (start_i) state_nx = SR_FLUSH;
            SR_FLUSH:  state_nx = (RST_CYCLES > 1) ? SR_SETTLE : SR_READY;
            SR_SETTLE: if (last) state_nx = SR_READY;
            default:   state_nx = SR_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SR_READY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == SR_SETTLE && !last) begin
                cnt <= cnt + CW'(1);
            end else begin
                cnt <= '0;
            end
        end
    end

    always_comb begin
        clear_o = 1'b0;
        done_o  = 1'b0;
        unique case (state)
            SR_READY:  done_o  = 1'b1;
            SR_FLUSH:  clear_o = 1'b1;
            SR_SETTLE: clear_o = 1'b1;
            default:   clear_o = 1'b1;
        endcase
    end

    AST_SR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && done_o) |=> !done_o) else $error("reset-done stayed high"); // R11

    AST_SR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> clear_o) else $error("reset started without clearing"); // R11

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int unsigned NUM_Q      = 4,
    parameter int unsigned Q_DEPTH    = 4,
    parameter int unsigned NUM_U      = 4,
    parameter int unsigned RST_CYCLES = 4,
    parameter logic [3:0]  REV_MAJOR  = 4'd2,
    parameter logic [3:0]  REV_MINOR  = 4'd1,
    localparam int unsigned DATA_W    = 32,
    localparam int unsigned EV_W      = 2 * NUM_Q,
    localparam int unsigned CNT_W     = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [8:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [NUM_U-1:0]  irq_o,
    output logic              idle_auto_o,
    output logic [1:0]        idle_mode_o
);

    logic              wr_cyc;
    logic              rd_cyc;
    logic              srst_clear;
    logic              srst_done;
    logic              srst_start;
    logic              cfg_auto;
    logic [1:0]        cfg_mode;

    logic [NUM_Q-1:0]  push;
    logic [NUM_Q-1:0]  pop;
    logic [NUM_Q-1:0]  q_full;
    logic [NUM_Q-1:0]  q_pushed;
    logic [NUM_Q-1:0]  q_freed;
    logic [DATA_W-1:0] q_head  [NUM_Q];
    logic [CNT_W-1:0]  q_count [NUM_Q];
    logic [EV_W-1:0]   events;

    logic [EV_W-1:0]   u_status [NUM_U];
    logic [EV_W-1:0]   u_enable [NUM_U];
    logic [NUM_U-1:0]  st_w1c;
    logic [NUM_U-1:0]  en_we;

    assign wr_cyc = bus_sel_i && bus_wr_i;
    assign rd_cyc = bus_sel_i && !bus_wr_i;

    // Configuration register and soft-reset request
    assign srst_start = wr_cyc && (bus_addr_i == OFS_CFG) && bus_wdata_i[CFG_SRST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_auto <= 1'b0;
            cfg_mode <= 2'b00;
        end else if (srst_clear) begin
            cfg_auto <= 1'b0;
            cfg_mode <= 2'b00;
        end else if (wr_cyc && bus_addr_i == OFS_CFG && !bus_wdata_i[CFG_SRST_BIT]) begin
            cfg_auto <= bus_wdata_i[CFG_AUTOIDLE_BIT];
            cfg_mode <= bus_wdata_i[CFG_MODE_LSB +: 2];
        end
    end

    assign idle_auto_o = cfg_auto;
    assign idle_mode_o = cfg_mode;

    mbx_srst_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (srst_start),
        .clear_o (srst_clear),
        .done_o  (srst_done)
    );

    // Message queues
    for (genvar m = 0; m < NUM_Q; m++) begin : g_queue
        localparam logic [ADDR_W-1:0] MSG_A = BASE_MSG + ADDR_W'(4 * m);

        assign push[m] = wr_cyc && (bus_addr_i == MSG_A);
        assign pop[m]  = rd_cyc && (bus_addr_i == MSG_A);

        mbx_queue #(
            .DATA_W (DATA_W),
            .DEPTH  (Q_DEPTH)
        ) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (srst_clear),
            .push_i   (push[m]),
            .pop_i    (pop[m]),
            .wdata_i  (bus_wdata_i),
            .head_o   (q_head[m]),
            .count_o  (q_count[m]),
            .full_o   (q_full[m]),
            .pushed_o (q_pushed[m]),
            .freed_o  (q_freed[m])
        );

        assign events[2*m]   = q_pushed[m];
        assign events[2*m+1] = q_freed[m];
    end

    // Per-user interrupt banks
    for (genvar u = 0; u < NUM_U; u++) begin : g_user
        localparam logic [ADDR_W-1:0] ST_A = BASE_IRQ + ADDR_W'(8 * u);
        localparam logic [ADDR_W-1:0] EN_A = BASE_IRQ + ADDR_W'(8 * u + 4);

        assign st_w1c[u] = wr_cyc && (bus_addr_i == ST_A);
        assign en_we[u]  = wr_cyc && (bus_addr_i == EN_A);

        mbx_irq_bank #(
            .EV_W (EV_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (srst_clear),
            .ev_i     (events),
            .st_w1c_i (st_w1c[u]),
            .en_we_i  (en_we[u]),
            .wdata_i  (bus_wdata_i[EV_W-1:0]),
            .status_o (u_status[u]),
            .enable_o (u_enable[u]),
            .irq_o    (irq_o[u])
        );
    end

    // Read path
    always_comb begin
        bus_rdata_o = '0;
        if (rd_cyc) begin
            if (bus_addr_i == OFS_REV) begin
                bus_rdata_o = {24'd0, REV_MAJOR, REV_MINOR};
            end
            if (bus_addr_i == OFS_CFG) begin
                bus_rdata_o[CFG_AUTOIDLE_BIT]      = cfg_auto;
                bus_rdata_o[CFG_MODE_LSB +: 2]     = cfg_mode;
            end
            if (bus_addr_i == OFS_STAT) begin
                bus_rdata_o[0] = srst_done;
            end
            for (int m = 0; m < NUM_Q; m++) begin
                if (bus_addr_i == BASE_MSG + ADDR_W'(4 * m)) begin
                    bus_rdata_o = q_head[m];
                end
                if (bus_addr_i == BASE_FST + ADDR_W'(4 * m)) begin
                    bus_rdata_o = {31'd0, q_full[m]};
                end
                if (bus_addr_i == BASE_MST + ADDR_W'(4 * m)) begin
                    bus_rdata_o = DATA_W'(q_count[m]);
                end
            end
            for (int u = 0; u < NUM_U; u++) begin
                if (bus_addr_i == BASE_IRQ + ADDR_W'(8 * u)) begin
                    bus_rdata_o = DATA_W'(u_status[u]);
                end
                if (bus_addr_i == BASE_IRQ + ADDR_W'(8 * u + 4)) begin
                    bus_rdata_o = DATA_W'(u_enable[u]);
                end
            end
        end
    end

    AST_IRQ_QUIET_AFTER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        srst_clear |=> (irq_o == '0)) else $error("interrupt after soft reset"); // R11

    AST_SINGLE_QUEUE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_pushed | q_freed) <= 1) else $error("events on two queues at once"); // R12

endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    localparam int NQ = 4;
    localparam int NU = 4;
    localparam int DEPTH = 4;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NU-1:0] irq;
    logic        idle_auto;
    logic [1:0]  idle_mode;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ipc_mailbox #(
        .NUM_Q (NQ), .Q_DEPTH (DEPTH), .NUM_U (NU), .RST_CYCLES (RSTC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_sel_i (sel), .bus_wr_i (wr),
        .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
        .irq_o (irq), .idle_auto_o (idle_auto), .idle_mode_o (idle_mode)
    );

    function automatic logic [8:0] a_msg(int m);  return 9'(12'h040 + 4 * m); endfunction
    function automatic logic [8:0] a_fst(int m);  return 9'(12'h080 + 4 * m); endfunction
    function automatic logic [8:0] a_mst(int m);  return 9'(12'h0C0 + 4 * m); endfunction
    function automatic logic [8:0] a_ist(int u);  return 9'(12'h100 + 8 * u); endfunction
    function automatic logic [8:0] a_ien(int u);  return 9'(12'h104 + 8 * u); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk);
        #1 sel = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d, exp);
    endtask

    task automatic irq_chk(input string req, input logic [NU-1:0] exp);
        @(negedge clk);
        #1 chk(req, 32'(irq), 32'(exp));
    endtask

    task automatic clear_all_status();
        for (int u = 0; u < NU; u++) bus_write(a_ist(u), 32'hFF);
    endtask

    task automatic t_reset_state();
        read_chk("R1 cfg", 9'h010, 32'h0);
        read_chk("R1 reset-done", 9'h014, 32'h1);
        for (int m = 0; m < NQ; m++) begin
            read_chk("R1 count", a_mst(m), 32'h0);
            read_chk("R1 full", a_fst(m), 32'h0);
        end
        for (int u = 0; u < NU; u++) begin
            read_chk("R1 status", a_ist(u), 32'h0);
            read_chk("R1 enable", a_ien(u), 32'h0);
        end
        irq_chk("R1 irq", '0);
        read_chk("R9 revision", 9'h000, 32'h21);
    endtask

    task automatic t_fifo_order();
        bus_write(a_msg(1), 32'hA1A1_0001);
        bus_write(a_msg(1), 32'hB2B2_0002);
        bus_write(a_msg(1), 32'hC3C3_0003);
        read_chk("R2 count", a_mst(1), 32'd3);
        read_chk("R12 other queue q0", a_mst(0), 32'd0);
        read_chk("R12 other queue q2", a_mst(2), 32'd0);
        read_chk("R2 pop1", a_msg(1), 32'hA1A1_0001);
        read_chk("R2 pop2", a_msg(1), 32'hB2B2_0002);
        read_chk("R2 count after pops", a_mst(1), 32'd1);
        read_chk("R2 pop3", a_msg(1), 32'hC3C3_0003);
        read_chk("R2 count empty", a_mst(1), 32'd0);
    endtask

    task automatic t_full_drop();
        for (int i = 0; i < DEPTH; i++) begin
            read_chk("R3 not full yet", a_fst(2), 32'h0);
            bus_write(a_msg(2), 32'h5000 + 32'(i));
        end
        read_chk("R3 full flag", a_fst(2), 32'h1);
        bus_write(a_msg(2), 32'hDEAD_BEEF);
        read_chk("R3 count after drop", a_mst(2), 32'(DEPTH));
        read_chk("R3 first pop", a_msg(2), 32'h5000);
        read_chk("R3 full cleared", a_fst(2), 32'h0);
        for (int i = 1; i < DEPTH; i++) read_chk("R3 contents kept", a_msg(2), 32'h5000 + 32'(i));
        read_chk("R3 empty after drain", a_mst(2), 32'd0);
    endtask

    task automatic t_empty_read();
        read_chk("R4 empty pop data", a_msg(3), 32'h0);
        read_chk("R4 empty count", a_mst(3), 32'h0);
    endtask

    task automatic t_events();
        clear_all_status();
        read_chk("R7 cleared", a_ist(0), 32'h0);
        bus_write(a_msg(0), 32'h0000_0AAA);
        for (int u = 0; u < NU; u++) read_chk("R5 push event", a_ist(u), 32'h01);
        bus_write(a_ien(2), 32'h01);
        read_chk("R8 enable readback", a_ien(2), 32'h01);
        irq_chk("R8 irq user2", 4'b0100);
        bus_write(a_ist(2), 32'h00);
        read_chk("R7 zero write keeps", a_ist(2), 32'h01);
        bus_write(a_ist(2), 32'h01);
        read_chk("R7 one write clears", a_ist(2), 32'h00);
        read_chk("R7 other user kept", a_ist(0), 32'h01);
        irq_chk("R8 irq after clear", 4'b0000);
        for (int i = 1; i < DEPTH; i++) bus_write(a_msg(0), 32'h0B00 + 32'(i));
        clear_all_status();
        bus_write(a_msg(0), 32'hFFFF_0000);
        read_chk("R5 dropped push no event", a_ist(0), 32'h0);
        read_chk("R6 pop from full", a_msg(0), 32'h0000_0AAA);
        read_chk("R6 not-full event", a_ist(0), 32'h02);
        read_chk("R6 not-full event user3", a_ist(3), 32'h02);
        bus_write(a_ien(1), 32'h02);
        irq_chk("R8 irq user1", 4'b0010);
        clear_all_status();
        read_chk("R6 pop not from full", a_msg(0), 32'h0B01);
        read_chk("R6 no event", a_ist(0), 32'h0);
        irq_chk("R8 irq quiet", 4'b0000);
        read_chk("R2 drain", a_msg(0), 32'h0B02);
        read_chk("R2 drain", a_msg(0), 32'h0B03);
        bus_write(a_ien(1), 32'h00);
        bus_write(a_ien(2), 32'h00);
    endtask

    task automatic t_rev_cfg();
        bus_write(9'h000, 32'hFFFF_FFFF);
        read_chk("R9 revision write ignored", 9'h000, 32'h21);
        bus_write(9'h010, 32'h19);
        read_chk("R10 cfg readback", 9'h010, 32'h19);
        irq_chk("R10 idle_auto", '0);
        chk("R10 idle_auto pin", 32'(idle_auto), 32'h1);
        chk("R10 idle_mode pin", 32'(idle_mode), 32'h3);
        bus_write(9'h010, 32'hE5);
        read_chk("R10 unused bits zero", 9'h010, 32'h01);
        bus_write(9'h010, 32'h10);
        read_chk("R10 smart idle", 9'h010, 32'h10);
        chk("R10 idle_mode smart", 32'(idle_mode), 32'h2);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        int zeros;
        bus_write(9'h010, 32'h11);
        bus_write(a_ien(1), 32'hFF);
        bus_write(a_msg(1), 32'h1234);
        bus_write(a_msg(1), 32'h5678);
        irq_chk("R8 irq before soft reset", 4'b0010);
        bus_write(9'h010, 32'h02);
        zeros = 0;
        for (int i = 0; i < 20; i++) begin
            bus_read(9'h014, d);
            if (d[0] == 1'b1) break;
            zeros++;
        end
        chk("R11 reset-done low cycles", 32'(zeros), 32'(RSTC));
        read_chk("R11 done", 9'h014, 32'h1);
        read_chk("R11 queue emptied", a_mst(1), 32'h0);
        read_chk("R11 queue data gone", a_msg(1), 32'h0);
        read_chk("R11 status cleared", a_ist(1), 32'h0);
        read_chk("R11 enable cleared", a_ien(1), 32'h0);
        read_chk("R11 cfg cleared", 9'h010, 32'h0);
        irq_chk("R11 irq cleared", 4'b0000);
        bus_write(a_msg(3), 32'h7777);
        read_chk("R11 usable after", a_mst(3), 32'h1);
        read_chk("R11 usable data", a_msg(3), 32'h7777);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        t_fifo_order();
        t_full_drop();
        t_empty_read();
        t_events();
        t_rev_cfg();
        t_soft_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1-chain actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule